// File: doc/BRIEF.md
# PIO Cycle Timing Sequencer

This block runs one programmed-I/O transfer at a time on a parallel disk-style device bus. The host side presents a request: a register index, a direction flag, and a 16-bit word to write. It also presents a 32-bit timing word made of four 8-bit clock counts. The block puts the index on the device address lines. It pulses the active-low read or write strobe and drives the write word onto the data bus for the required window. On a read it latches the word that the device returns. Every count is in system clock cycles, and a count of N gives a phase N+1 clocks long.

A device-ready input can extend the strobe phase for slow devices. A control input decides whether that input is used. When the input is used, the strobe stays low until the ready line, passed through a two-stage synchronizer, reads high. The done pulse marks the end of the hold phase, so a host acknowledge need not wait for the recovery time. The block takes a new request only after the recovery time has elapsed.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, req_ready is 1, dev_rd_n and dev_wr_n are 1, dev_dout_oe is 0, cyc_done is 0, and rd_data is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. For the next T1+1 clocks, dev_addr carries req_reg and both strobes stay high.
- R3: After setup, the strobe of the selected direction (dev_wr_n when req_write=1, dev_rd_n when req_write=0) is low for T2+1 clocks unless the ready extension applies. The other strobe stays high.
- R4: After the strobe, a hold phase of T4+1 clocks keeps dev_addr unchanged with both strobes high.
- R5: A recovery phase of Teoc+1 clocks follows the hold phase. During recovery req_ready is 0. req_ready returns to 1 on the next clock.
- R6: The timing word fields are: bits 7:0 T1 (setup), bits 15:8 T2 (strobe), bits 23:16 T4 (hold), bits 31:24 Teoc (recovery). The word is latched when the request is accepted.
- R7: When rdy_en is 0, dev_rdy has no effect on any output timing.
- R8: When rdy_en is 1, the strobe ends on the later of two edges: the edge where the T2 count expires, and the third rising clock edge after dev_rdy goes high. dev_rdy must have been low at the accept edge.
- R9: A read cycle captures dev_din on the clock edge at which the strobe deasserts. rd_data holds that value until the next read capture, and write cycles leave it unchanged.
- R10: dev_dout_oe is 1 only during a write cycle, from the first strobe clock through the last hold clock. While it is 1, dev_dout equals the request's write word.
- R11: cyc_done is a single-clock pulse in the first recovery clock of each cycle.
- R12: req_valid has no effect while req_ready is 0. The address and write word of the cycle in progress stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_reg | input | 4 | Device register index |
| req_wdata | input | 16 | Word to write |
| timing_word | input | 32 | Four packed 8-bit phase counts |
| rdy_en | input | 1 | Use device ready to extend the strobe |
| req_ready | output | 1 | Idle and able to accept a request |
| cyc_done | output | 1 | One-clock pulse at end of hold |
| rd_data | output | 16 | Last captured read word |
| dev_addr | output | 4 | Device address lines |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_dout | output | 16 | Data driven to the device |
| dev_dout_oe | output | 1 | Output enable for dev_dout |
| dev_din | input | 16 | Data returned by the device |
| dev_rdy | input | 1 | Device ready, asynchronous |

## Verification
Counting edges from the accept edge as 1, setup covers edges 1 to T1+1. The hold phase begins at edge H, which is T1+T2+3, or the later of that and R+3 when the ready line is used and rises after sample R. Done is due at H+T4+1, and req_ready returns at H+T4+Teoc+2. The bench samples every output at each falling edge within that window and compares it with the value expected for that edge index. It drives dev_din with a value that changes every cycle, so the check of rd_data confirms that the capture took place exactly at edge H.

// File: rtl/pio_seq_pkg.sv
// Shared types for the PIO cycle sequencer.
// Assumes: a cycle visits the phases strictly in the order listed.
package pio_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } pio_phase_e;

    // Field order inside the timing word, lowest field first.
    localparam int F_SETUP  = 0;
    localparam int F_STROBE = 1;
    localparam int F_HOLD   = 2;
    localparam int F_EOC    = 3;
    localparam int N_FIELDS = 4;

endpackage

// File: rtl/pio_rdy_sync.sv
// Multi-stage synchronizer for the asynchronous device ready line.
// Assumes: STAGES >= 2. Resets to "not ready", so a strobe never ends early after reset.
module pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pio_phase_ctl.sv
// Phase controller: steps setup, strobe, hold and recovery, each lasting its count plus one clock.
// Assumes: timing_word is sampled only on the accept edge. rdy_sync has already been synchronized.
module pio_phase_ctl
    import pio_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int TW_W = N_FIELDS * CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [TW_W-1:0] timing_word,
    input  logic            rdy_en,
    input  logic            rdy_sync,
    output pio_phase_e      phase,
    output logic            accept,
    output logic            strobe_end,
    output logic            done
);

    logic [TW_W-1:0]  tw_q;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    // Decode the accept and end-of-strobe events for this clock.
    always_comb begin
        cnt_zero   = (cnt == '0);
        accept     = (phase == PH_IDLE) && req_valid;
        strobe_end = (phase == PH_STROBE) && cnt_zero && (!rdy_en || rdy_sync);
    end

    // Advance the phase, reload the down-counter, and emit the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tw_q  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        tw_q  <= timing_word;
                        cnt   <= timing_word[F_SETUP*CNT_W +: CNT_W];
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        cnt   <= tw_q[F_STROBE*CNT_W +: CNT_W];
                        phase <= PH_STROBE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (strobe_end) begin
                        cnt   <= tw_q[F_HOLD*CNT_W +: CNT_W];
                        phase <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        cnt   <= tw_q[F_EOC*CNT_W +: CNT_W];
                        done  <= 1'b1;
                        phase <= PH_RECOV;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) phase <= PH_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pio_bus_io.sv
// Device-side bus stage: latches the request, forms the strobes and output enable, and captures read data.
// Assumes: accept fires only in idle. strobe_end marks the last strobe clock.
module pio_bus_io
    import pio_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  pio_phase_e        phase,
    input  logic              strobe_end,
    input  logic [DATA_W-1:0] dev_din,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_dout,
    output logic              dev_dout_oe,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic              strobe_on;

    // Hold the request fields for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_reg;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
        end
    end

    // Capture device data on the edge that ends a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_data <= '0;
        else if (strobe_end && !wr_q) rd_data <= dev_din;
    end

    // Form the strobes and the data enable from the current phase.
    always_comb begin
        strobe_on   = (phase == PH_STROBE);
        dev_rd_n    = !(strobe_on && !wr_q);
        dev_wr_n    = !(strobe_on && wr_q);
        dev_dout_oe = wr_q && (strobe_on || (phase == PH_HOLD));
        dev_addr    = addr_q;
        dev_dout    = wdata_q;
    end

endmodule

// File: rtl/pio_cycle_seq.sv
// Top of the PIO cycle sequencer: runs one programmed-I/O device cycle per accepted request.
// Assumes: one request at a time. dev_rdy is asynchronous to clk.
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int SYNC_STGS = 2,
    localparam int TW_W     = N_FIELDS * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TW_W-1:0]   timing_word,
    input  logic              rdy_en,
    output logic              req_ready,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic [DATA_W-1:0] dev_dout,
    output logic              dev_dout_oe,
    input  logic [DATA_W-1:0] dev_din,
    input  logic              dev_rdy
);

    pio_phase_e phase;
    logic       accept;
    logic       strobe_end;
    logic       rdy_sync;

    pio_rdy_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_rdy),
        .sync_out (rdy_sync)
    );

    pio_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .timing_word (timing_word),
        .rdy_en      (rdy_en),
        .rdy_sync    (rdy_sync),
        .phase       (phase),
        .accept      (accept),
        .strobe_end  (strobe_end),
        .done        (cyc_done)
    );

    pio_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_write   (req_write),
        .req_reg     (req_reg),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .strobe_end  (strobe_end),
        .dev_din     (dev_din),
        .dev_addr    (dev_addr),
        .dev_dout    (dev_dout),
        .dev_dout_oe (dev_dout_oe),
        .dev_rd_n    (dev_rd_n),
        .dev_wr_n    (dev_wr_n),
        .rd_data     (rd_data)
    );

    // Idle is the only phase that takes a request.
    assign req_ready = (phase == PH_IDLE);

endmodule

// File: rtl/pio_cycle_chk.sv
// Protocol checker for pio_cycle_seq, attached by bind. Observes ports only.
module pio_cycle_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cyc_done,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              dev_rd_n,
    input logic              dev_wr_n,
    input logic              dev_dout_oe
);

    // R3: never both strobes low together.
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!dev_rd_n, !dev_wr_n}));

    // R10: a read strobe never coincides with driven data.
    assert_read_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rd_n |-> !dev_dout_oe);

    // R10: a write strobe always has data driven.
    assert_write_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_wr_n |-> dev_dout_oe);

    // R11: done lasts a single clock.
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // R5: done falls inside recovery, never while idle.
    assert_done_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> !req_ready);

    // R5: while idle the bus is quiet.
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dev_rd_n && dev_wr_n && !dev_dout_oe));

    // R12: address steady across consecutive strobe clocks.
    assert_addr_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |=> ((dev_rd_n && dev_wr_n) || $stable(dev_addr)));

endmodule

bind pio_cycle_seq pio_cycle_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pio_cycle_seq.sv
// Bench for pio_cycle_seq: directed mode words and random timing, checked per cycle against a computed timeline.
module sim_pio_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] timing_word = '0;
    logic        rdy_en = 1'b0;
    logic        req_ready, cyc_done, dev_rd_n, dev_wr_n, dev_dout_oe;
    logic [15:0] rd_data, dev_dout;
    logic [3:0]  dev_addr;
    logic [15:0] dev_din = '0;
    logic        dev_rdy = 1'b0;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [15:0] last_rd = '0;

    always #2 clk = ~clk;

    pio_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata), .timing_word(timing_word),
        .rdy_en(rdy_en), .req_ready(req_ready), .cyc_done(cyc_done),
        .rd_data(rd_data), .dev_addr(dev_addr), .dev_rd_n(dev_rd_n),
        .dev_wr_n(dev_wr_n), .dev_dout(dev_dout), .dev_dout_oe(dev_dout_oe),
        .dev_din(dev_din), .dev_rdy(dev_rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (%0t)", tag, act, exp, $time);
        end
    endtask

    // Edge index (accept edge = 1) at which the hold phase begins.
    function automatic int hold_start(int t1, int t2, bit en, int r);
        int nat = t1 + t2 + 3;
        if (en && (r + 3 > nat)) return r + 3;
        return nat;
    endfunction

    // One cycle: r is the sample index after which dev_rdy rises (0 = high from the start).
    task automatic run_txn(input bit wr, input logic [3:0] rg, input logic [15:0] wd,
                           input logic [31:0] tw, input bit en, input int r);
        int t1 = int'(tw[7:0]);
        int t2 = int'(tw[15:8]);
        int t4 = int'(tw[23:16]);
        int te = int'(tw[31:24]);
        int h = hold_start(t1, t2, en, r);
        int last = h + t4 + te + 2;
        logic [15:0] pat = 16'($urandom);
        @(negedge clk);
        chk("R5 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = wd;
        timing_word = tw; rdy_en = en;
        dev_rdy = (en && r == 0);
        dev_din = pat ^ 16'd1;
        for (int j = 1; j <= last; j++) begin
            bit stb, oe_e, rdy_e, done_e;
            logic [3:0] vec, exp;
            string tag;
            @(negedge clk);
            stb    = (j >= t1 + 2) && (j <= h - 1);
            oe_e   = wr && (j >= t1 + 2) && (j <= h + t4);
            rdy_e  = (j == last);
            done_e = (j == h + t4 + 1);
            vec = {req_ready, dev_rd_n, dev_wr_n, dev_dout_oe};
            exp = {rdy_e, !(stb && !wr), !(stb && wr), oe_e};
            if (j <= t1 + 1)      tag = "R2 setup";
            else if (j < h)       tag = (j > t1 + t2 + 2) ? "R8 ready stretch" :
                                        (en ? "R3 strobe" : "R7 strobe ready ignored");
            else if (j <= h + t4) tag = "R4 hold";
            else if (j < last)    tag = "R5 recovery";
            else                  tag = "R6 cycle length";
            chk(tag, {28'd0, vec}, {28'd0, exp});
            chk("R11 done pulse", {31'd0, cyc_done}, {31'd0, done_e});
            if (j <= h + t4) chk("R12 address held", {28'd0, dev_addr}, {28'd0, rg});
            if (oe_e) chk("R10 write data", {16'd0, dev_dout}, {16'd0, wd});
            if (j == h) begin
                if (!wr) last_rd = pat ^ 16'(h);
                chk("R9 read capture", {16'd0, rd_data}, {16'd0, last_rd});
            end
            // Drive stimulus for the next edge.
            dev_din = pat ^ 16'(j + 1);
            if (en && j == r) dev_rdy = 1'b1;
            if (j == 1) begin
                req_reg = ~rg; req_wdata = ~wd; req_write = ~wr; timing_word = '0;
            end
            if (j == 2) req_valid = 1'b0;
        end
        chk("R9 read data held", {16'd0, rd_data}, {16'd0, last_rd});
    endtask

    initial begin
        logic [31:0] modes [5];
        modes[0] = 32'h18021C04; modes[1] = 32'h05011C02; modes[2] = 32'h01011C00;
        modes[3] = 32'h07000700; modes[4] = 32'h02000600;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {26'd0, req_ready, dev_rd_n, dev_wr_n, dev_dout_oe, cyc_done, 1'b0},
                                {26'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        chk("R1 reset read data", {16'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        // R6: each standard mode word, read and write, with and without ready.
        for (int m = 0; m < 5; m++) begin
            run_txn(1'b0, 4'(m + 8), 16'h0000, modes[m], 1'b0, 0);
            run_txn(1'b1, 4'(m), 16'hA5C0 ^ 16'(m), modes[m], 1'b1, 0);
            run_txn(1'b0, 4'(15 - m), 16'h0000, modes[m], 1'b1, 45);
        end
        // Minimum counts and stretched strobes.
        run_txn(1'b1, 4'hF, 16'hFFFF, 32'h0, 1'b0, 0);
        run_txn(1'b0, 4'h0, 16'h0, 32'h0, 1'b1, 1);
        run_txn(1'b0, 4'h3, 16'h0, 32'h0, 1'b1, 20);
        run_txn(1'b1, 4'h7, 16'h1234, 32'h01020304, 1'b1, 9);
        // Random timing, direction, ready usage and ready delay.
        for (int k = 0; k < 60; k++) begin
            logic [31:0] tw = {4'd0, 4'($urandom), 4'd0, 4'($urandom),
                               4'd0, 4'($urandom), 4'd0, 4'($urandom)};
            run_txn(1'($urandom), 4'($urandom), 16'($urandom), tw,
                    1'($urandom), int'($urandom % 50));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule